// File: doc/BRIEF.md
# Display Controller SPI Register Master

This block turns single register requests into the byte-framed SPI traffic that a small TFT display controller expects for configuration access. The requester presents an operation code, an 8-bit register index and a 16-bit write value, then pulses a start strobe. The block produces every chip-select frame that the operation needs and returns the read result when a read completes. When the last frame has been closed it raises a one-cycle done pulse.

Each frame opens with a start byte. The start byte carries a device identity bit, a register-select bit (index register or data) and a direction bit. A read has to skip the junk byte that the display returns after the start byte. Every byte that is sent can optionally be inverted for boards that have an inverting level shifter. The serial clock for register traffic is kept at or below a set ceiling. If the requested divider would exceed that ceiling, the divider is clamped when the design is built.

Top module: `spi_reg_master`

## Requirements
- R1: Every frame starts with a start byte. Its bits 7..3 are 01110, bit 2 is dev_id_i, bit 1 is the select bit (0 = index register, 1 = register data) and bit 0 is the direction bit (0 = write, 1 = read).
- R2: op_i = 0 (index set) produces one 24-bit frame: a start byte with select 0 and direction 0, then 0x00, then index_i.
- R3: op_i = 1 (register write) produces the R2 frame and then a second, separate 24-bit frame: a start byte with select 1 and direction 0, then wdata_i[15:8], then wdata_i[7:0].
- R4: op_i = 2 (register read) produces the R2 frame and then a 24-bit frame: a start byte with select 1 and direction 1, then two 0x00 bytes. rdata_o takes the last two received bytes, the earlier byte in bits 15..8, and is valid when done_o is high. Index-set and write operations leave rdata_o unchanged.
- R5: op_i = 3 (status read) produces one 32-bit frame: a start byte with select 0 and direction 1, then three 0x00 bytes. The first byte received after the start byte is discarded. rdata_o is {received byte 2, received byte 3}.
- R6: cs_no goes high between the frames of one operation and stays high for at least one SCLK half period. done_o is high only while cs_no is high.
- R7: When tx_inv_i is 1, every transmitted bit is the complement of its R1 to R5 value. This includes the start byte and the filler bytes.
- R8: Bytes are sent MSB first in SPI mode 3. sclk_o is high whenever cs_no is high. mosi_o changes only on a falling sclk_o edge. miso_i is sampled on the rising edge.
- R9: Each SCLK half period, including the half period from chip select low to the first clock edge, lasts exactly max(DIV_HALF, ceil(CLK_HZ / (2*MAX_SCLK_HZ))) clock cycles.
- R10: busy_o rises the cycle after an accepted start_i and falls in the cycle in which done_o pulses for one cycle. A start_i that arrives while busy_o is high is ignored.
- R11: After reset, cs_no = 1, sclk_o = 1, busy_o = 0, done_o = 0 and rdata_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled while idle |
| op_i | input | 2 | 0 index set, 1 write, 2 read, 3 status read |
| index_i | input | 8 | Register index |
| wdata_i | input | 16 | Write value |
| dev_id_i | input | 1 | Device identity bit placed in the start byte (tie to 1 for the usual default) |
| tx_inv_i | input | 1 | Invert all transmitted bits |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Last read or status result |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data in |

## Verification
On every cycle, the embedded properties check four things. The serial clock idles high outside a frame. MOSI holds still whenever the clock is high. No clock edge follows the previous edge in fewer than the clamped half-period count. Done is a single-cycle pulse that arrives with chip select released and busy low. The bench sweeps every operation code against both inversion settings and both identity values, using boundary index and write data. This is the only way to check the exact byte content of each frame, the number of frames per operation, the dropped dummy byte in a status read, and the rejection of a start that arrives mid-operation. The bench also measures the exact half-period length and the inter-frame chip-select gap against the clamp formula.

// File: rtl/spi_reg_pkg.sv
`timescale 1ns/1ps
package spi_reg_pkg;
  typedef enum logic [1:0] {
    OP_INDEX  = 2'd0,
    OP_WRITE  = 2'd1,
    OP_READ   = 2'd2,
    OP_STATUS = 2'd3
  } op_e;

  typedef enum logic [1:0] {M_IDLE, M_FIRST, M_SECOND} mst_e;

  typedef enum logic [2:0] {X_IDLE, X_LEAD, X_LOW, X_HIGH, X_GAP} xfr_e;

  localparam int FRAME_W = 32;
  localparam int NB_W    = $clog2(FRAME_W + 1);

  function automatic logic [7:0] start_byte(input logic id, input logic rs, input logic rw);
    return {5'b01110, id, rs, rw};
  endfunction
endpackage

// File: rtl/spi_reg_tick.sv
`timescale 1ns/1ps
module spi_reg_tick #(
  parameter int HALF = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/spi_reg_frame.sv
`timescale 1ns/1ps
module spi_reg_frame
  import spi_reg_pkg::*;
#(
  parameter int HALF = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [NB_W-1:0]    nbits_i,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               cs_no,
  output logic               fin_o,
  output logic [15:0]        rx_o
);
  localparam int GW = $clog2(HALF + 1);

  xfr_e               st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [NB_W-1:0]    nb_q, cnt_q;
  logic               tick;

  spi_reg_tick #(.HALF(HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != X_IDLE),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= X_IDLE;
      sh_q   <= '0;
      nb_q   <= '0;
      cnt_q  <= '0;
      sclk_o <= 1'b1;
      mosi_o <= 1'b0;
      cs_no  <= 1'b1;
      fin_o  <= 1'b0;
      rx_o   <= '0;
    end else begin
      fin_o <= 1'b0;
      case (st_q)
        X_IDLE: if (go_i) begin
          sh_q  <= frame_i;
          nb_q  <= nbits_i;
          cnt_q <= '0;
          cs_no <= 1'b0;
          st_q  <= X_LEAD;
        end
        X_LEAD: if (tick) begin
          sclk_o <= 1'b0;
          mosi_o <= sh_q[FRAME_W-1];
          sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
          st_q   <= X_LOW;
        end
        X_LOW: if (tick) begin
          sclk_o <= 1'b1;
          rx_o   <= {rx_o[14:0], miso_i};
          cnt_q  <= cnt_q + 1'b1;
          st_q   <= X_HIGH;
        end
        X_HIGH: if (tick) begin
          if (cnt_q == nb_q) begin
            cs_no <= 1'b1;
            st_q  <= X_GAP;
          end else begin
            sclk_o <= 1'b0;
            mosi_o <= sh_q[FRAME_W-1];
            sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
            st_q   <= X_LOW;
          end
        end
        X_GAP: if (tick) begin
          st_q  <= X_IDLE;
          fin_o <= 1'b1;
        end
        default: st_q <= X_IDLE;
      endcase
    end
  end

  // cycles since the last sclk toggle, saturating
  logic          sclk_d;
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b1;
      gap_q  <= GW'(HALF);
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o != sclk_d)      gap_q <= GW'(1);
      else if (gap_q < GW'(HALF)) gap_q <= gap_q + 1'b1;
    end
  end

  p_sclk_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);
  p_mosi_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));
  p_half_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != sclk_d) |-> (gap_q >= GW'(HALF)));
endmodule

// File: rtl/spi_reg_master.sv
`timescale 1ns/1ps
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int MAX_SCLK_HZ = 4_000_000,
  parameter int DIV_HALF    = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  op_i,
  input  logic [7:0]  index_i,
  input  logic [15:0] wdata_i,
  input  logic        dev_id_i,
  input  logic        tx_inv_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  output logic        cs_no,
  input  logic        miso_i
);
  localparam int MIN_HALF = (CLK_HZ + 2 * MAX_SCLK_HZ - 1) / (2 * MAX_SCLK_HZ);
  localparam int HALF     = (DIV_HALF > MIN_HALF) ? DIV_HALF : MIN_HALF;

  mst_e               st_q;
  op_e                op_q;
  logic [15:0]        wd_q;
  logic               go_q, fin;
  logic [FRAME_W-1:0] frame_q, first_f, second_f, inv_m;
  logic [NB_W-1:0]    nb_q, first_nb;
  logic [15:0]        rx;

  assign inv_m = {FRAME_W{tx_inv_i}};

  always_comb begin
    if (op_e'(op_i) == OP_STATUS) begin
      first_f  = {start_byte(dev_id_i, 1'b0, 1'b1), 24'h0};
      first_nb = NB_W'(32);
    end else begin
      first_f  = {start_byte(dev_id_i, 1'b0, 1'b0), 8'h00, index_i, 8'h00};
      first_nb = NB_W'(24);
    end
    if (op_q == OP_READ) second_f = {start_byte(dev_id_i, 1'b1, 1'b1), 16'h0, 8'h00};
    else                 second_f = {start_byte(dev_id_i, 1'b1, 1'b0), wd_q, 8'h00};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= M_IDLE;
      op_q    <= OP_INDEX;
      wd_q    <= '0;
      go_q    <= 1'b0;
      frame_q <= '0;
      nb_q    <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      go_q   <= 1'b0;
      done_o <= 1'b0;
      case (st_q)
        M_IDLE: if (start_i) begin
          op_q    <= op_e'(op_i);
          wd_q    <= wdata_i;
          frame_q <= first_f ^ inv_m;
          nb_q    <= first_nb;
          go_q    <= 1'b1;
          st_q    <= M_FIRST;
        end
        M_FIRST: if (fin) begin
          if (op_q == OP_WRITE || op_q == OP_READ) begin
            frame_q <= second_f ^ inv_m;
            nb_q    <= NB_W'(24);
            go_q    <= 1'b1;
            st_q    <= M_SECOND;
          end else begin
            if (op_q == OP_STATUS) rdata_o <= rx;
            done_o <= 1'b1;
            st_q   <= M_IDLE;
          end
        end
        M_SECOND: if (fin) begin
          if (op_q == OP_READ) rdata_o <= rx;
          done_o <= 1'b1;
          st_q   <= M_IDLE;
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != M_IDLE);

  spi_reg_frame #(.HALF(HALF)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go_q),
    .frame_i (frame_q),
    .nbits_i (nb_q),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_no   (cs_no),
    .fin_o   (fin),
    .rx_o    (rx)
  );

  p_idle_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
  p_done_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !busy_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (busy_o || done_o));
endmodule

// File: tb/sim_spi_reg_master.sv
`timescale 1ns/1ps
module sim_spi_reg_master;
  localparam int CLK_HZ   = 50_000_000;
  localparam int MAX_HZ   = 4_000_000;
  localparam int DIV_HALF = 2;
  localparam int MINH     = (CLK_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ);
  localparam int HALF_EXP = (DIV_HALF > MINH) ? DIV_HALF : MINH;
  localparam longint HALF_NS = HALF_EXP * 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dev_id = 1'b1, tx_inv = 1'b0, miso = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] idx = 8'h00;
  logic [15:0] wd = 16'h0;
  logic busy, done, sclk, mosi, cs_n;
  logic [15:0] rdata;

  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  spi_reg_master #(.CLK_HZ(CLK_HZ), .MAX_SCLK_HZ(MAX_HZ), .DIV_HALF(DIV_HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .index_i(idx),
    .wdata_i(wd), .dev_id_i(dev_id), .tx_inv_i(tx_inv), .busy_o(busy),
    .done_o(done), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .cs_no(cs_n), .miso_i(miso)
  );

  // slave model and frame monitor
  logic        mon_en = 1'b0;
  logic [7:0]  mb [4];
  logic [31:0] cur = 0;
  int          bitpos = 0;
  logic [31:0] fr_data [4];
  int          fr_bits [4];
  int          nfr = 0;
  longint      t_last = 0, cs_rise_t = 0;
  longint      hmin = 64'h7fffffff, hmax = 0, csgap_min = 64'h7fffffff;
  logic        in_frame_gap = 1'b0;

  always @(negedge cs_n) if (mon_en) begin
    cur = 0;
    bitpos = 0;
    miso = mb[0][7];
    if (in_frame_gap && ($time - cs_rise_t) < csgap_min) csgap_min = $time - cs_rise_t;
    t_last = $time;
  end

  always @(negedge sclk) if (mon_en && !cs_n) begin
    if (bitpos < 32) miso = mb[bitpos / 8][7 - (bitpos % 8)];
  end

  always @(sclk) if (mon_en && !cs_n) begin
    if ($time - t_last < hmin) hmin = $time - t_last;
    if ($time - t_last > hmax) hmax = $time - t_last;
    t_last = $time;
  end

  always @(posedge sclk) if (mon_en && !cs_n) begin
    cur = {cur[30:0], mosi};
    bitpos++;
  end

  always @(posedge cs_n) if (mon_en) begin
    if ($time - t_last < hmin) hmin = $time - t_last;
    if ($time - t_last > hmax) hmax = $time - t_last;
    if (nfr < 4) begin
      fr_data[nfr] = cur;
      fr_bits[nfr] = bitpos;
    end
    nfr++;
    cs_rise_t = $time;
    in_frame_gap = 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sb(input logic id, input logic rs, input logic rw, input logic inv);
    return {5'b01110, id, rs, rw} ^ {8{inv}};
  endfunction

  logic [15:0] last_rd = 16'h0;

  task automatic do_access(input logic [1:0] o, input logic [7:0] ix, input logic [15:0] w,
                           input logic inv, input logic id, input logic [7:0] seed);
    logic [7:0]  f;
    logic [31:0] e1, e2;
    int          en, eb1;
    logic [15:0] erd;
    int          waited;
    logic        got;
    f = {8{inv}};
    for (int k = 0; k < 4; k++) mb[k] = 8'h96 ^ 8'(k * 8'h27) ^ seed;
    e1 = {8'h00, sb(id, 1'b0, 1'b0, inv), f, ix ^ f};
    eb1 = 24; en = 1; e2 = 0; erd = last_rd;
    case (o)
      2'd1: begin en = 2; e2 = {8'h00, sb(id, 1'b1, 1'b0, inv), w[15:8] ^ f, w[7:0] ^ f}; end
      2'd2: begin en = 2; e2 = {8'h00, sb(id, 1'b1, 1'b1, inv), f, f}; erd = {mb[1], mb[2]}; end
      2'd3: begin e1 = {sb(id, 1'b0, 1'b1, inv), f, f, f}; eb1 = 32; erd = {mb[2], mb[3]}; end
      default: ;
    endcase
    @(negedge clk);
    nfr = 0; in_frame_gap = 1'b0;
    op = o; idx = ix; wd = w; tx_inv = inv; dev_id = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after start", 32'(busy), 32'd1);
    got = 1'b0; waited = 0;
    while (!got && waited < 4000) begin
      @(negedge clk);
      waited++;
      if (waited == 20) begin   // start while busy must be ignored
        op = 2'd3; idx = ~ix; start = 1'b1;
      end else start = 1'b0;
      if (done) got = 1'b1;
    end
    start = 1'b0;
    check("R10 done seen", 32'(got), 32'd1);
    check("R6 cs high at done", 32'(cs_n), 32'd1);
    check("R10 busy low at done", 32'(busy), 32'd0);
    check("R2 frame count", 32'(nfr), 32'(en));
    check("R1 R2 R5 first frame", fr_data[0], e1);
    check("R5 first frame bits", 32'(fr_bits[0]), 32'(eb1));
    if (en == 2) begin
      check("R3 R4 second frame", fr_data[1], e2);
      check("R3 R4 second frame bits", 32'(fr_bits[1]), 32'd24);
    end
    check((o == 2'd3) ? "R5 status data" : "R4 read data", 32'(rdata), 32'(erd));
    last_rd = erd;
    @(negedge clk);
    check("R10 done one cycle", 32'(done), 32'd0);
    check("R10 idle after done", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) mb[k] = 8'h00;
    for (int k = 0; k < 4; k++) begin fr_data[k] = 0; fr_bits[k] = 0; end
    repeat (3) @(negedge clk);
    check("R11 cs_n reset", 32'(cs_n), 32'd1);
    check("R11 sclk reset", 32'(sclk), 32'd1);
    check("R11 busy reset", 32'(busy), 32'd0);
    check("R11 done reset", 32'(done), 32'd0);
    check("R11 rdata reset", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (2) @(negedge clk);
    for (int o = 0; o < 4; o++)
      for (int inv = 0; inv < 2; inv++)
        for (int id = 0; id < 2; id++)
          for (int v = 0; v < 4; v++) begin
            logic [7:0] ix;
            ix = 8'(v * 8'h55) ^ 8'(o);
            // R7 inversion sweep and R1 identity bit covered by inv/id loops
            do_access(2'(o), ix, {~ix, ix ^ 8'h3C}, inv[0], id[0], 8'(v * 8'h11 + o * 8'h40));
          end
    check("R9 min half period ns", 32'(hmin), 32'(HALF_NS));
    check("R9 max half period ns", 32'(hmax), 32'(HALF_NS));
    check("R6 cs gap at least half period", 32'(csgap_min >= HALF_NS), 32'd1);
    check("R8 sclk idle high", 32'(sclk), 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule